// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Threshold Masking

This block sits next to a processor core and arbitrates a set of level-sensitive interrupt request lines. Each line has a programmable priority byte, an enable bit, and a shared threshold register set by the core. A smaller priority value means a more urgent interrupt. Only the upper bits of each priority byte are stored. The block keeps a small stack of the levels of the handlers now running. It signals the core with the most urgent request that passes the enable, the threshold and the preemption rule.

The core takes an interrupt with an acknowledge strobe, which pushes the winner's level onto the stack. It finishes the handler with an end-of-handler strobe, which pops the stack and restores the previous level. A request can preempt the running handler only when it is strictly more urgent. A nonzero threshold holds off every request from that level down to the least urgent one. More urgent requests still get through. A byte-wide write/read port reaches the priority, threshold and enable registers.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Register map: address i (0..NUM_IRQ-1) holds line i's priority byte, address NUM_IRQ holds the threshold byte, and address NUM_IRQ+1+k holds the enable bits of lines 8k..8k+7, with line 8k+b in bit b. Only the PRIO_BITS most significant bits of a priority byte are stored. The lower bits are dropped on write and read back as zero. The threshold and enable bytes read back as written.
- R2: A priority write whose set bits all fall in the dropped low bits stores level 0, the most urgent level.
- R3: The signalled request is the one with the numerically smallest stored priority. When levels tie, the lowest line index wins.
- R4: With a nonzero threshold M, a request whose effective priority byte (stored bits with zeros below) is numerically greater than or equal to M is never signalled. A request whose effective priority is below M is still signalled.
- R5: A threshold of 0 masks nothing.
- R6: A request held off by the threshold is signalled one cycle after a write sets the threshold above its priority or to zero, while the request is still asserted.
- R7: While a handler is active, a request is signalled only if its level is strictly below the active level. A request at an equal level is not signalled.
- R8: Each accepted acknowledge pushes the signalled level, and each end-of-handler pops one entry. With an empty stack the active level output is 2^PRIO_BITS. An end-of-handler on an empty stack has no effect. While the stack holds STACK_DEPTH entries, no request is signalled.
- R9: A line whose enable bit is 0 is never signalled, whatever its priority or the threshold.
- R10: irq_o and irq_id_o are registered. A change at the request inputs shows at them after the next rising edge and not before it. An accepted acknowledge (ack_i while irq_o is high) drops irq_o at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NUM_IRQ | Level request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt signalled to the core |
| irq_id_o | output | ID_W | Index of the signalled line |
| ack_i | input | 1 | Core takes the signalled interrupt |
| eoi_i | input | 1 | Core finishes the current handler |
| active_lvl_o | output | PRIO_BITS+1 | Level of the running handler, 2^PRIO_BITS when idle |

## Verification
Request changes show on irq_o and irq_id_o one rising edge later. A register write first lands at one edge, and its effect on arbitration shows after the edge that follows. The active level changes at the edge that takes an acknowledge or an end-of-handler. The same edge drops irq_o, and the next edge shows the new arbitration result. The bench drives every input on a falling edge and samples on a later falling edge. For each check it waits the edge count given above, and it reads registers half a cycle after setting the address. Checking R10 includes a sample taken before any edge, to confirm the output did not move early.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  function automatic int unsigned en_bytes(input int unsigned n);
    return (n + 7) / 8;
  endfunction

  function automatic int unsigned id_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs #(
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned PRIO_BITS = 3,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [7:0]                        wdata_i,
  output logic [7:0]                        rdata_o,
  output logic [NUM_IRQ-1:0][PRIO_BITS-1:0] lvl_o,
  output logic [7:0]                        mask_o,
  output logic [NUM_IRQ-1:0]                en_o
);
  localparam int unsigned EN_BYTES = prio_irq_pkg::en_bytes(NUM_IRQ);
  localparam int unsigned MASK_ADR = NUM_IRQ;
  localparam int unsigned EN_ADR   = NUM_IRQ + 1;

  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] lvl_q;
  logic [7:0]                        mask_q;
  logic [NUM_IRQ-1:0]                en_q;
  logic [EN_BYTES*8-1:0]             en_pad;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q[g] <= '0;
        en_q[g]  <= 1'b0;
      end else if (we_i) begin
        if (addr_i == ADDR_W'(g)) lvl_q[g] <= wdata_i[7 -: PRIO_BITS];
        if (addr_i == ADDR_W'(EN_ADR + g / 8)) en_q[g] <= wdata_i[g % 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (we_i && addr_i == ADDR_W'(MASK_ADR)) mask_q <= wdata_i;
  end

  always_comb begin
    en_pad = '0;
    en_pad[NUM_IRQ-1:0] = en_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (addr_i == ADDR_W'(i)) rdata_o[7 -: PRIO_BITS] = lvl_q[i];
    if (addr_i == ADDR_W'(MASK_ADR)) rdata_o = mask_q;
    for (int k = 0; k < EN_BYTES; k++)
      if (addr_i == ADDR_W'(EN_ADR + k)) rdata_o = en_pad[8*k +: 8];
  end

  assign lvl_o  = lvl_q;
  assign mask_o = mask_q;
  assign en_o   = en_q;

  // R1: dropped priority bits always read as zero
  a_r1_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < ADDR_W'(NUM_IRQ)) |-> (rdata_o[7-PRIO_BITS:0] == '0));
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned PRIO_BITS = 3,
  parameter int unsigned ID_W      = 3
) (
  input  logic [NUM_IRQ-1:0]                req_i,
  input  logic [NUM_IRQ-1:0]                en_i,
  input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] lvl_i,
  input  logic [7:0]                        mask_i,
  input  logic [PRIO_BITS:0]                active_lvl_i,
  input  logic                              room_i,
  output logic                              found_o,
  output logic [ID_W-1:0]                   id_o,
  output logic [PRIO_BITS-1:0]              lvl_o
);
  logic [NUM_IRQ-1:0] elig;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_elig
    logic [7:0] eff;
    always_comb begin
      eff = '0;
      eff[7 -: PRIO_BITS] = lvl_i[g];
    end
    assign elig[g] = req_i[g] && en_i[g] && room_i &&
                     ((mask_i == 8'd0) || (eff < mask_i)) &&
                     ({1'b0, lvl_i[g]} < active_lvl_i);
  end

  // descending scan: on a tie the lower index overwrites
  always_comb begin
    logic                 hit;
    logic [ID_W-1:0]      win_id;
    logic [PRIO_BITS-1:0] win_lvl;
    hit     = 1'b0;
    win_id  = '0;
    win_lvl = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (elig[i] && (!hit || lvl_i[i] <= win_lvl)) begin
        hit     = 1'b1;
        win_id  = ID_W'(i);
        win_lvl = lvl_i[i];
      end
    end
    found_o = hit;
    id_o    = win_id;
    lvl_o   = win_lvl;
  end
endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack #(
  parameter int unsigned PRIO_BITS   = 3,
  parameter int unsigned STACK_DEPTH = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic                 pop_i,
  input  logic [PRIO_BITS-1:0] push_lvl_i,
  output logic [PRIO_BITS:0]   active_lvl_o,
  output logic                 full_o
);
  localparam int unsigned CW = $clog2(STACK_DEPTH + 1);
  localparam int unsigned SW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam logic [PRIO_BITS:0] IDLE = {1'b1, {PRIO_BITS{1'b0}}};

  logic [CW-1:0]                         cnt_q;
  logic [STACK_DEPTH-1:0][PRIO_BITS-1:0] stk_q;
  logic [SW-1:0]                         top_idx, wr_idx;
  logic                                  empty;

  assign empty   = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(STACK_DEPTH));
  assign top_idx = SW'(cnt_q - 1'b1);
  assign wr_idx  = SW'(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stk_q <= '0;
    end else if (push_i && pop_i && !empty) begin
      stk_q[top_idx] <= push_lvl_i;   // pop and push together replace the top
    end else if (push_i && !full_o) begin
      stk_q[wr_idx] <= push_lvl_i;
      cnt_q         <= cnt_q + 1'b1;
    end else if (pop_i && !empty) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_lvl_o = empty ? IDLE : {1'b0, stk_q[top_idx]};

  a_r8_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(STACK_DEPTH));
  a_r8_pop_empty_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty) |=> (active_lvl_o == IDLE));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned NUM_IRQ     = 8,
  parameter int unsigned PRIO_BITS   = 3,
  parameter int unsigned STACK_DEPTH = 4,
  parameter int unsigned ADDR_W      = $clog2(NUM_IRQ + 1 + prio_irq_pkg::en_bytes(NUM_IRQ)),
  parameter int unsigned ID_W        = prio_irq_pkg::id_width(NUM_IRQ)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IRQ-1:0]   irq_req_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o,
  output logic                 irq_o,
  output logic [ID_W-1:0]      irq_id_o,
  input  logic                 ack_i,
  input  logic                 eoi_i,
  output logic [PRIO_BITS:0]   active_lvl_o
);
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] lvl_w;
  logic [7:0]                        mask_w;
  logic [NUM_IRQ-1:0]                en_w;
  logic                              found_w, full_w, take_w;
  logic [ID_W-1:0]                   id_w;
  logic [PRIO_BITS-1:0]              win_lvl_w, irq_lvl_q;
  logic [PRIO_BITS:0]                active_w;
  logic                              irq_q;
  logic [ID_W-1:0]                   id_q;

  prio_irq_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .lvl_o(lvl_w), .mask_o(mask_w), .en_o(en_w));

  prio_irq_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_arb (
    .req_i(irq_req_i), .en_i(en_w), .lvl_i(lvl_w), .mask_i(mask_w),
    .active_lvl_i(active_w), .room_i(!full_w),
    .found_o(found_w), .id_o(id_w), .lvl_o(win_lvl_w));

  assign take_w = ack_i && irq_q;

  prio_irq_stack #(.PRIO_BITS(PRIO_BITS), .STACK_DEPTH(STACK_DEPTH)) u_stack (
    .clk_i, .rst_ni, .push_i(take_w), .pop_i(eoi_i), .push_lvl_i(irq_lvl_q),
    .active_lvl_o(active_w), .full_o(full_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q     <= 1'b0;
      id_q      <= '0;
      irq_lvl_q <= '0;
    end else begin
      irq_q     <= take_w ? 1'b0 : found_w;
      id_q      <= id_w;
      irq_lvl_q <= win_lvl_w;
    end
  end

  assign irq_o        = irq_q;
  assign irq_id_o     = id_q;
  assign active_lvl_o = active_w;

  logic [7:0] irq_eff;
  always_comb begin
    irq_eff = '0;
    irq_eff[7 -: PRIO_BITS] = irq_lvl_q;
  end

  a_r7_strict_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ({1'b0, irq_lvl_q} < active_w));
  a_r4_threshold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(mask_w) == 8'd0 || irq_eff < $past(mask_w)));
  a_r9_enabled_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en_w[id_w] && irq_req_i[id_w]));
  a_r10_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> !irq_o);
  a_r8_full_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_w |=> !irq_o);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq_req_i = '0;
  logic       reg_we_i = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;
  logic [2:0] irq_id_o;
  logic       ack_i = 1'b0;
  logic       eoi_i = 1'b0;
  logic [3:0] active_lvl_o;

  int total = 0;
  int bad   = 0;
  int prio_m [8];
  logic [7:0] en_m = '0;
  int mask_m = 0;
  int act_m = 8;

  always #2.5 clk_i = ~clk_i;

  prio_irq_ctrl u_dut (.*);

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int adr, input int val);
    reg_we_i = 1'b1; reg_addr_i = 4'(adr); reg_wdata_i = 8'(val);
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (adr < 8) prio_m[adr] = val / 32;
    else if (adr == 8) mask_m = val;
    else en_m = 8'(val);
  endtask

  // model of R3/R4/R5/R7/R9: returns winning line or -1
  function automatic int pick(input logic [7:0] r, input bit full);
    int best = -1;
    if (full) return -1;
    for (int i = 7; i >= 0; i--)
      if (r[i] && en_m[i] && (mask_m == 0 || prio_m[i] * 32 < mask_m) &&
          prio_m[i] < act_m && (best < 0 || prio_m[i] <= prio_m[best]))
        best = i;
    return best;
  endfunction

  task automatic chk_pick(input logic [7:0] r, input string tag);
    int e;
    irq_req_i = r;
    @(negedge clk_i);
    e = pick(r, 1'b0);
    chk(irq_o ? int'(irq_id_o) : -1, e, tag);
  endtask

  task automatic do_ack();
    ack_i = 1'b1; @(negedge clk_i); ack_i = 1'b0;
  endtask

  task automatic do_eoi();
    eoi_i = 1'b1; @(negedge clk_i); eoi_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) prio_m[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state (R8, R10)
    chk(irq_o, 0, "R10 reset irq");
    chk(active_lvl_o, 8, "R8 reset idle level");
    reg_addr_i = 4'd0; #1;
    chk(reg_rdata_o, 0, "R1 reset prio read");
    @(negedge clk_i);

    // R1: every value into one priority byte
    for (int v = 0; v < 256; v++) begin
      wr(3, v);
      reg_addr_i = 4'd3; #1;
      chk(reg_rdata_o, v & 8'hE0, "R1 prio readback");
      @(negedge clk_i);
    end
    wr(8, 8'h5A); reg_addr_i = 4'd8; #1; chk(reg_rdata_o, 8'h5A, "R1 threshold readback");
    @(negedge clk_i);
    wr(9, 8'hFF); reg_addr_i = 4'd9; #1; chk(reg_rdata_o, 8'hFF, "R1 enable readback");
    @(negedge clk_i);
    wr(8, 0);

    // R2: low-bit-only write yields most urgent level
    wr(0, 8'h20); wr(1, 8'h1F); @(negedge clk_i);
    reg_addr_i = 4'd1; #1; chk(reg_rdata_o, 0, "R2 low-bit write reads zero");
    @(negedge clk_i);
    chk_pick(8'b11, "R2 low-bit write wins");
    chk(irq_id_o, 1, "R2 winner id");

    // R3: all request patterns under two priority sets, one with ties
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 8; i++) wr(i, (s == 0 ? (i * 5 + 3) % 8 : i % 3) * 32);
      @(negedge clk_i);
      for (int r = 0; r < 256; r++) chk_pick(8'(r), "R3 arbitration");
    end

    // R9: enable sweep with every line requesting
    for (int e = 0; e < 256; e++) begin
      wr(9, e);
      @(negedge clk_i);
      chk(irq_o ? int'(irq_id_o) : -1, pick(8'hFF, 1'b0), "R9 enable gating");
    end
    wr(9, 8'hFF);
    irq_req_i = '0;

    // R4/R5: threshold sweep for each level on line 0
    for (int p = 0; p < 8; p++) begin
      wr(0, p * 32);
      irq_req_i = 8'b1;
      for (int m = 0; m < 256; m++) begin
        wr(8, m);
        @(negedge clk_i);
        chk(irq_o, (m == 0 || p * 32 < m) ? 1 : 0, m == 0 ? "R5 zero threshold" : "R4 threshold");
      end
    end
    irq_req_i = '0;

    // R6: held by threshold, then released
    wr(3, 8'h60); wr(8, 8'h60); irq_req_i = 8'b1000;
    repeat (4) @(negedge clk_i);
    chk(irq_o, 0, "R6 held under threshold");
    wr(8, 8'h80);
    chk(irq_o, 0, "R6 not before arbitration edge");
    @(negedge clk_i);
    chk(irq_o, 1, "R6 released irq");
    chk(irq_id_o, 3, "R6 released id");
    wr(8, 0); irq_req_i = '0;

    // R10: latency and ack
    for (int i = 0; i < 8; i++) wr(i, i * 32);
    @(negedge clk_i);
    irq_req_i = 8'h80; #1;
    chk(irq_o, 0, "R10 no early output");
    @(negedge clk_i);
    chk(irq_o, 1, "R10 irq after one edge");
    chk(irq_id_o, 7, "R10 id after one edge");
    do_ack(); act_m = 7;
    chk(irq_o, 0, "R10 ack drops irq");
    chk(active_lvl_o, 7, "R8 push level 7");
    @(negedge clk_i);
    chk(irq_o, 0, "R7 equal level no preempt");
    // R7/R8: nest to full depth
    for (int l = 6; l >= 4; l--) begin
      irq_req_i[l] = 1'b1;
      @(negedge clk_i);
      chk(irq_o ? int'(irq_id_o) : -1, l, "R7 strict preempt");
      do_ack(); act_m = l;
      chk(active_lvl_o, l, "R8 push level");
    end
    irq_req_i[0] = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(irq_o, 0, "R8 full stack quiet");
    do_eoi();
    chk(active_lvl_o, 5, "R8 pop restores");
    @(negedge clk_i);
    chk(irq_o ? int'(irq_id_o) : -1, 0, "R8 room after pop");
    irq_req_i = '0;
    for (int l = 6; l <= 8; l++) begin
      do_eoi();
      chk(active_lvl_o, l, "R8 pop sequence");
    end
    do_eoi();
    chk(active_lvl_o, 8, "R8 pop on empty");
    @(negedge clk_i);
    chk(irq_o, 0, "R8 idle no irq");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule